// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits on the cartridge side of an 8-bit processor bus with 16-bit addresses. The processor reads program ROM and battery-free external RAM through it. It selects which 16 kB ROM page appears in the upper half of the ROM space, and which 8 kB RAM page appears in the external RAM window. The processor configures the block by storing into addresses that would otherwise be read-only ROM. A store to the lower selection range picks the ROM page. A store to the next range picks the RAM page. A store of a key byte to the lowest range opens access to the RAM.

The outputs are the upper ROM address lines, the full RAM address with its page bits, and the RAM chip-enable and write-enable. A read-data multiplexer returns ROM data, RAM data, or an idle 0xFF to the processor. The RAM gate is a two-state machine. State GATE_LOCKED moves to GATE_OPEN on transition UNLOCK, which is a store of 0x0A into 0x0000–0x1FFF. GATE_OPEN returns to GATE_LOCKED on transition RELOCK, which is a store of any other byte into that range. Every other cycle holds the current state.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM page is 1, the RAM page is 0 and the RAM gate is in GATE_LOCKED.
- R2: For any address in 0x0000–0x3FFF, `rom_addr` equals {five zero bits, cpu_addr[13:0]}.
- R3: For any address in 0x4000–0x7FFF, `rom_addr` equals {ROM page, cpu_addr[13:0]}. For any address below 0x8000, `cpu_rdata` equals `rom_rdata`.
- R4: A store anywhere in 0x2000–0x3FFF loads the ROM page from data bits [4:0]. Data bits [7:5] are ignored. The new page is visible from the cycle after the store.
- R5: A ROM page request whose bits [4:0] are zero (for example 0x00 or 0x20) selects page 1. The ROM page is never 0.
- R6: A store anywhere in 0x4000–0x5FFF loads the RAM page from data bits [1:0]. `ram_addr` equals {RAM page, cpu_addr[12:0]}.
- R7: A store of exactly 0x0A into 0x0000–0x1FFF opens the RAM. A store of any other byte there closes it.
- R8: While the RAM is closed, `ram_ce` and `ram_we` stay low, and reads in 0xA000–0xBFFF return 0xFF. A store there leaves the RAM contents unchanged.
- R9: While the RAM is open, an access in 0xA000–0xBFFF raises `ram_ce`. `ram_we` follows `cpu_wr` there, and `cpu_rdata` equals `ram_rdata`.
- R10: Stores into 0x6000–0x7FFF change neither page register nor the RAM gate.
- R11: Outside 0x0000–0x7FFF and 0xA000–0xBFFF, `cpu_rdata` is 0xFF and `ram_ce` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor store data |
| cpu_wr | input | 1 | Store strobe, one cycle per store |
| cpu_rdata | output | 8 | Read data returned to the processor |
| rom_rdata | input | 8 | Data from the ROM device |
| rom_addr | output | 19 | ROM device address {page, offset} |
| ram_rdata | input | 8 | Data from the RAM device |
| ram_addr | output | 15 | RAM device address {page, offset} |
| ram_ce | output | 1 | RAM chip enable |
| ram_we | output | 1 | RAM write enable |

## Verification
Assertions check several rules on every cycle:
- The ROM page is never zero.
- The fixed ROM window always drives page zero.
- A closed RAM never sees an enable and reads back 0xFF.
- Write enable never rises without chip enable.
- Stores to the spare range leave all three pieces of state unchanged.
- Each key or page store lands in the following cycle.

Only the bench's sweeps can show the rest:
- All 256 page and key bytes decode correctly.
- The page bits really index separate RAM contents.
- A store made while the RAM was closed is absent when it is reopened.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

    // Address regions, indexed by cpu_addr[15:13].
    typedef enum logic [2:0] {
        RGN_ENABLE = 3'd0,  // 0x0000-0x1FFF: RAM key stores
        RGN_ROMSEL = 3'd1,  // 0x2000-0x3FFF: ROM page stores
        RGN_RAMSEL = 3'd2,  // 0x4000-0x5FFF: RAM page stores
        RGN_SPARE  = 3'd3,  // 0x6000-0x7FFF: stores ignored
        RGN_VIDEO  = 3'd4,  // 0x8000-0x9FFF: not cartridge
        RGN_XRAM   = 3'd5,  // 0xA000-0xBFFF: external RAM window
        RGN_WORK   = 3'd6,  // 0xC000-0xDFFF: not cartridge
        RGN_HIGH   = 3'd7   // 0xE000-0xFFFF: not cartridge
    } region_t;

    typedef enum logic {
        GATE_LOCKED = 1'b0,
        GATE_OPEN   = 1'b1
    } gate_state_t;

    localparam logic [7:0] UNLOCK_KEY = 8'h0A;
    localparam logic [7:0] IDLE_BYTE  = 8'hFF;

endpackage

// File: rtl/cart_addr_decode.sv
module cart_addr_decode
    import cart_bank_pkg::*;
(
    input  logic [2:0] addr_hi,
    output region_t    region,
    output logic       rom_space,
    output logic       fixed_space
);
    always_comb begin
        region = RGN_HIGH;
        unique case (addr_hi)
            3'd0: region = RGN_ENABLE;
            3'd1: region = RGN_ROMSEL;
            3'd2: region = RGN_RAMSEL;
            3'd3: region = RGN_SPARE;
            3'd4: region = RGN_VIDEO;
            3'd5: region = RGN_XRAM;
            3'd6: region = RGN_WORK;
            3'd7: region = RGN_HIGH;
        endcase
    end

    assign rom_space   = ~addr_hi[2];
    assign fixed_space = ~addr_hi[2] & ~addr_hi[1];
endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs #(
    parameter int ROM_BANK_W = 5,
    parameter int RAM_BANK_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rom_sel_wr,
    input  logic                  ram_sel_wr,
    input  logic [ROM_BANK_W-1:0] rom_req,
    input  logic [RAM_BANK_W-1:0] ram_req,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic [RAM_BANK_W-1:0] ram_bank
);
    localparam logic [ROM_BANK_W-1:0] ROM_FIRST = ROM_BANK_W'(1);

    logic [ROM_BANK_W-1:0] rom_fixed;

    // A request of page zero is steered to page one.
    assign rom_fixed = (rom_req == '0) ? ROM_FIRST : rom_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rom_bank <= ROM_FIRST;
            ram_bank <= '0;
        end else begin
            if (rom_sel_wr) rom_bank <= rom_fixed;
            if (ram_sel_wr) ram_bank <= ram_req;
        end
    end

    // R5
    rom_bank_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_bank != '0);

    // R4
    rom_bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel_wr && rom_req != '0) |=> rom_bank == $past(rom_req));

    // R5
    rom_bank_zero_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel_wr && rom_req == '0) |=> rom_bank == ROM_FIRST);

    // R6
    ram_bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_sel_wr |=> ram_bank == $past(ram_req));
endmodule

// File: rtl/cart_ram_gate.sv
module cart_ram_gate
    import cart_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  region_t    region,
    input  logic       cpu_wr,
    input  logic [7:0] cpu_wdata,
    output logic       ram_open,
    output logic       ram_ce,
    output logic       ram_we
);
    gate_state_t state, state_nxt;
    logic        key_wr;
    logic        key_match;

    assign key_wr    = cpu_wr && (region == RGN_ENABLE);
    assign key_match = (cpu_wdata == UNLOCK_KEY);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GATE_LOCKED;
        else        state <= state_nxt;
    end

    // Transitions: UNLOCK and RELOCK
    always_comb begin
        state_nxt = state;
        unique case (state)
            GATE_LOCKED: if (key_wr && key_match)  state_nxt = GATE_OPEN;
            GATE_OPEN:   if (key_wr && !key_match) state_nxt = GATE_LOCKED;
        endcase
    end

    // Outputs
    always_comb begin
        ram_open = 1'b0;
        ram_ce   = 1'b0;
        ram_we   = 1'b0;
        unique case (state)
            GATE_LOCKED: ;
            GATE_OPEN: begin
                ram_open = 1'b1;
                ram_ce   = (region == RGN_XRAM);
                ram_we   = (region == RGN_XRAM) && cpu_wr;
            end
        endcase
    end

    // R7
    unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_match) |=> ram_open);

    // R7
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && !key_match) |=> !ram_open);

    // R9
    we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ram_ce);
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cart_bank_pkg::*;
#(
    parameter int ROM_BANK_W = 5,
    parameter int RAM_BANK_W = 2,
    localparam int ROM_ADDR_W = ROM_BANK_W + 14,
    localparam int RAM_ADDR_W = RAM_BANK_W + 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           cpu_addr,
    input  logic [7:0]            cpu_wdata,
    input  logic                  cpu_wr,
    output logic [7:0]            cpu_rdata,
    input  logic [7:0]            rom_rdata,
    output logic [ROM_ADDR_W-1:0] rom_addr,
    input  logic [7:0]            ram_rdata,
    output logic [RAM_ADDR_W-1:0] ram_addr,
    output logic                  ram_ce,
    output logic                  ram_we
);
    region_t               region;
    logic                  rom_space;
    logic                  fixed_space;
    logic                  ram_open;
    logic [ROM_BANK_W-1:0] rom_bank;
    logic [RAM_BANK_W-1:0] ram_bank;
    logic [ROM_BANK_W-1:0] rom_page;

    cart_addr_decode u_decode (
        .addr_hi     (cpu_addr[15:13]),
        .region      (region),
        .rom_space   (rom_space),
        .fixed_space (fixed_space)
    );

    cart_bank_regs #(
        .ROM_BANK_W (ROM_BANK_W),
        .RAM_BANK_W (RAM_BANK_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rom_sel_wr (cpu_wr && (region == RGN_ROMSEL)),
        .ram_sel_wr (cpu_wr && (region == RGN_RAMSEL)),
        .rom_req    (cpu_wdata[ROM_BANK_W-1:0]),
        .ram_req    (cpu_wdata[RAM_BANK_W-1:0]),
        .rom_bank   (rom_bank),
        .ram_bank   (ram_bank)
    );

    cart_ram_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .region    (region),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .ram_open  (ram_open),
        .ram_ce    (ram_ce),
        .ram_we    (ram_we)
    );

    assign rom_page = fixed_space ? '0 : rom_bank;
    assign rom_addr = {rom_page, cpu_addr[13:0]};
    assign ram_addr = {ram_bank, cpu_addr[12:0]};

    always_comb begin
        if (rom_space)   cpu_rdata = rom_rdata;
        else if (ram_ce) cpu_rdata = ram_rdata;
        else             cpu_rdata = IDLE_BYTE;
    end

    // R2
    fixed_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b00) |-> rom_addr[ROM_ADDR_W-1:14] == '0);

    // R8
    locked_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_open && cpu_addr[15:13] == 3'b101) |-> (cpu_rdata == IDLE_BYTE && !ram_we && !ram_ce));

    // R10
    spare_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b011) |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_open)));
endmodule

// File: tb/cart_bank_ctrl_test.sv
module cart_bank_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        cpu_wr;
    logic [7:0]  cpu_rdata;
    logic [7:0]  rom_rdata;
    logic [18:0] rom_addr;
    logic [7:0]  ram_rdata;
    logic [14:0] ram_addr;
    logic        ram_ce;
    logic        ram_we;

    int vectors = 0;
    int misses  = 0;
    logic we_seen;

    logic [7:0] ram_mem [0:63];

    always #10 clk = ~clk;

    cart_bank_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .rom_rdata(rom_rdata),
        .rom_addr(rom_addr), .ram_rdata(ram_rdata), .ram_addr(ram_addr),
        .ram_ce(ram_ce), .ram_we(ram_we)
    );

    function automatic logic [7:0] rom_byte(input logic [18:0] a);
        return (8'(a[18:14]) * 8'd7) ^ a[7:0];
    endfunction

    assign rom_rdata = rom_byte(rom_addr);
    assign ram_rdata = ram_mem[{ram_addr[14:13], ram_addr[3:0]}];

    always @(posedge clk)
        if (ram_we) ram_mem[{ram_addr[14:13], ram_addr[3:0]}] <= cpu_wdata;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic store(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        #1 we_seen = ram_we;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic peek(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_wr = 1'b0;
        #1;
    endtask

    initial begin
        #(20 * 190000);
        misses++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_wr = 1'b0; we_seen = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(16'h4000);
        check("R1 rom page", 32'(rom_addr), {13'd0, 5'd1, 14'h0});
        peek(16'hA000);
        check("R1 ram locked ce", 32'(ram_ce), 0);
        check("R1 locked read", 32'(cpu_rdata), 32'hFF);
        store(16'h0000, 8'h0A);
        peek(16'hA000);
        check("R1 ram page", 32'(ram_addr[14:13]), 0);
        store(16'h0000, 8'h00);

        // R4 R5 R2 R3 page sweep
        for (int v = 0; v < 256; v++) begin
            logic [4:0]  exp_pg;
            logic [13:0] off;
            logic [15:0] a;
            exp_pg = (v[4:0] == 5'd0) ? 5'd1 : v[4:0];
            a = 16'h2000 | 16'((v * 37) & 16'h1FFF);
            store(a, 8'(v));
            off = 14'((v * 53) & 16'h3FFF);
            peek(16'h4000 | 16'(off));
            check("R4 R5 switch page", 32'(rom_addr), {13'd0, exp_pg, off});
            check("R3 rom data", 32'(cpu_rdata), 32'(rom_byte({exp_pg, off})));
            off = 14'((v * 11) & 16'h3FFF);
            peek(16'(off));
            check("R2 fixed page", 32'(rom_addr), {18'd0, off});
        end

        // R10 spare stores ignored
        store(16'h2000, 8'h13);
        store(16'h4000, 8'h02);
        for (int v = 0; v < 256; v++) begin
            store(16'h6000 | 16'((v * 13) & 16'h1FFF), 8'(v));
            peek(16'h5000);
            check("R10 rom page kept", 32'(rom_addr[18:14]), 32'h13);
            peek(16'hA001);
            check("R10 gate kept", 32'(ram_ce), 0);
            check("R10 ram page kept", 32'(ram_addr[14:13]), 2);
        end

        // R7 key sweep
        for (int v = 0; v < 256; v++) begin
            store(16'h0000, 8'h0A);
            store(16'h1000 | 16'(v), 8'(v));
            peek(16'hA000);
            check("R7 key from open", 32'(ram_ce), (v == 10) ? 1 : 0);
            store(16'h1FFF, 8'h5C);
            store(16'h0ABC, 8'(v));
            peek(16'hB000);
            check("R7 key from locked", 32'(ram_ce), (v == 10) ? 1 : 0);
        end

        // R6 R9 paged RAM
        store(16'h0000, 8'h0A);
        for (int b = 0; b < 4; b++) begin
            store(16'h4000 | 16'(b * 300), 8'(b | (b << 4) | 8'hA0));
            for (int i = 0; i < 16; i++) begin
                store(16'hA000 | 16'(i) | 16'(b << 8), 8'((b * 16 + i) ^ 8'h5A));
                check("R9 write enable", 32'(we_seen), 1);
            end
        end
        for (int b = 0; b < 4; b++) begin
            store(16'h5FFF, 8'(b));
            for (int i = 0; i < 16; i++) begin
                logic [15:0] a;
                a = 16'hA000 | 16'(i) | 16'(i << 9);
                peek(a);
                check("R6 ram address", 32'(ram_addr), {17'd0, 2'(b), a[12:0]});
                check("R9 ram read", 32'(cpu_rdata), 32'(8'((b * 16 + i) ^ 8'h5A)));
                check("R9 read ce", 32'(ram_ce), 1);
            end
        end

        // R8 stores while locked
        store(16'h4000, 8'h01);
        store(16'h0000, 8'h00);
        store(16'hA003, 8'hEE);
        check("R8 no write enable", 32'(we_seen), 0);
        peek(16'hA003);
        check("R8 idle read", 32'(cpu_rdata), 32'hFF);
        store(16'h0000, 8'h0A);
        peek(16'hA003);
        check("R8 contents kept", 32'(cpu_rdata), 32'(8'((16 + 3) ^ 8'h5A)));

        // R11 non-cartridge space
        peek(16'h8000);
        check("R11 video idle", 32'(cpu_rdata), 32'hFF);
        check("R11 video ce", 32'(ram_ce), 0);
        peek(16'hC123);
        check("R11 work idle", 32'(cpu_rdata), 32'hFF);
        peek(16'hFFFF);
        check("R11 high idle", 32'(cpu_rdata), 32'hFF);
        check("R11 high ce", 32'(ram_ce), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule